// File: doc/BRIEF.md
# Key-Sequence Serviced Watchdog Timer

This block is a watchdog for a system that must prove it is alive by writing a fixed two-word key to a service register at regular intervals. Software programs an 8-bit timeout, in half-second units, into the control register. It then sets the enable bit, which starts the countdown and cannot be cleared afterwards. If the countdown runs out before the next valid key pair arrives, the block flags the timeout in a reset-status register. When the output mode bit is set, it also drives a reset request for a fixed number of clocks.

A prescaler divides the system clock into half-second ticks. Its division ratio is a parameter, so a simulation can use a short tick. The countdown counts ticks. A timeout field value of N gives an expiry (N+1) ticks after the counter was last loaded. After an expiry the counter restarts from the programmed timeout, so an unserviced watchdog keeps requesting resets. The register port is a simple single-cycle write strobe with a byte offset. Reads are combinational from the offset.

Top module: `wdt_keyseq`

## Requirements
- R1: After rst_ni is released, the control register reads 0x0000, the reset-status register reads 0x0000 and wdog_rst_o is low.
- R2: Register offsets are: control at 0, service at 2, reset status at 4. The control register reads back timeout in bits 15:8, mode bit 7, output-mode bit 3, enable bit 2 and mode bits 1 and 0. Bits 6:4 read as 0. The service register and any other offset read as 0.
- R3: A control write with bit 2 set enables the watchdog and loads the countdown from bits 15:8 of that same write.
- R4: Once enabled, the enable bit stays set, and writes with bit 2 clear do not stop the countdown.
- R5: The timeout field takes the latest written value while the watchdog is disabled. Control writes after enable leave it unchanged.
- R6: With timeout field N, wdog_rst_o rises exactly (N+1)*TICKS_PER_HALF_SECOND clock cycles after the edge that loaded the counter.
- R7: The counter reloads only when a service write of 0xAAAA follows a service write of 0x5555. A reload makes the next expiry occur exactly (N+1)*TICKS_PER_HALF_SECOND cycles after the 0xAAAA write. A lone 0xAAAA has no effect.
- R8: Any service write other than 0xAAAA that follows 0x5555 cancels the armed state, and a repeated 0x5555 keeps it armed.
- R9: When control bit 3 is set, each expiry drives wdog_rst_o high for exactly RST_PULSE_CYCLES cycles.
- R10: When control bit 3 is clear, an expiry leaves wdog_rst_o low.
- R11: An expiry sets bit 0 of the reset-status register. Writes do not clear it; only rst_ni does.
- R12: After an expiry the countdown restarts from the timeout field, so the next expiry follows (N+1)*TICKS_PER_HALF_SECOND cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register byte offset for read and write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| wdog_rst_o | output | 1 | Reset request pulse on expiry |

## Verification
The assertions check on every cycle that the enable bit and the timeout field stay frozen once enabled, and that a reload only coincides with a 0xAAAA service write. They also check that a reset pulse needs the output-mode bit, that the pulse never runs past its length, that the timeout-cause bit never drops, and that the service offset always reads zero. Only the bench scenarios can show that the expiry arrives on the exact cycle for each timeout value, and that broken, lone or repeated key writes move that cycle or leave it alone as required. The bench scenarios also show that the countdown repeats after expiry and that the cause bit survives writes but not reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [15:0] KEY_ARM  = 16'h5555;
  localparam logic [15:0] KEY_FIRE = 16'hAAAA;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_SVC  = 3'd2;
  localparam logic [2:0] OFS_STAT = 3'd4;

  typedef struct packed {
    logic [7:0] tout;
    logic       m7;
    logic       rst_out;
    logic       en;
    logic       m1;
    logic       m0;
  } ctrl_t;

  function automatic ctrl_t word_to_ctrl(input logic [15:0] w);
    ctrl_t c;
    c.tout    = w[15:8];
    c.m7      = w[7];
    c.rst_out = w[3];
    c.en      = w[2];
    c.m1      = w[1];
    c.m0      = w[0];
    return c;
  endfunction

  function automatic logic [15:0] ctrl_to_word(input ctrl_t c);
    return {c.tout, c.m7, 3'b000, c.rst_out, c.en, c.m1, c.m0};
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  ctrl_t wr_val_i,
  output ctrl_t ctrl_o,
  output logic  en_start_o
);
  ctrl_t ctrl_q;

  assign en_start_o = wr_i && !ctrl_q.en && wr_val_i.en;
  assign ctrl_o     = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q.m7      <= wr_val_i.m7;
      ctrl_q.rst_out <= wr_val_i.rst_out;
      ctrl_q.m1      <= wr_val_i.m1;
      ctrl_q.m0      <= wr_val_i.m0;
      if (!ctrl_q.en) ctrl_q.tout <= wr_val_i.tout;  // locked after enable
      if (wr_val_i.en) ctrl_q.en <= 1'b1;            // write-once
    end
  end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        svc_wr_i,
  input  logic [15:0] wdata_i,
  output logic        armed_o,
  output logic        reload_o
);
  logic armed_q;

  assign reload_o = svc_wr_i && armed_q && (wdata_i == KEY_FIRE);
  assign armed_o  = armed_q;

  // every service write re-evaluates the armed state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (svc_wr_i) armed_q <= (wdata_i == KEY_ARM);
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned TICKS = 16_000_000,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             expire_o
);
  localparam int unsigned PRE_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICKS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick     = (pre_q == PRE_MAX);
  assign expire_o = en_i && !load_i && tick && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      cnt_q <= load_val_i;
    end else if (en_i) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= (cnt_q == '0) ? reload_val_i : cnt_q - CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen #(
  parameter int unsigned PULSE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic rst_out_en_i,
  output logic wdog_rst_o,
  output logic cause_o
);
  localparam int unsigned PW = $clog2(PULSE + 1);

  logic [PW-1:0] len_q;
  logic          cause_q;

  assign wdog_rst_o = (len_q != '0);
  assign cause_o    = cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      if (expire_i) cause_q <= 1'b1;
      if (expire_i && rst_out_en_i) len_q <= PW'(PULSE);
      else if (len_q != '0)         len_q <= len_q - PW'(1);
    end
  end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int unsigned TICKS_PER_HALF_SECOND = 16_000_000,
  parameter int unsigned RST_PULSE_CYCLES      = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        wdog_rst_o
);
  localparam int unsigned TOUT_W = 8;

  ctrl_t             ctrl;
  ctrl_t             wr_val;
  logic              ctrl_wr, svc_wr;
  logic              en_start, reload, armed, expire, cause;
  logic              ctrl_en, ctrl_rst_out;
  logic [TOUT_W-1:0] tout_cur, load_val;

  assign ctrl_wr = reg_we_i && (reg_addr_i == OFS_CTRL);
  assign svc_wr  = reg_we_i && (reg_addr_i == OFS_SVC);
  assign wr_val  = word_to_ctrl(reg_wdata_i);

  assign ctrl_en      = ctrl.en;
  assign ctrl_rst_out = ctrl.rst_out;
  assign tout_cur     = ctrl.tout;
  // enable write loads the timeout carried in that same write
  assign load_val     = en_start ? wr_val.tout : tout_cur;

  wdt_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctrl_wr),
    .wr_val_i   (wr_val),
    .ctrl_o     (ctrl),
    .en_start_o (en_start)
  );

  wdt_key_seq u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .svc_wr_i (svc_wr),
    .wdata_i  (reg_wdata_i),
    .armed_o  (armed),
    .reload_o (reload)
  );

  wdt_countdown #(
    .TICKS (TICKS_PER_HALF_SECOND),
    .CNT_W (TOUT_W)
  ) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (ctrl_en),
    .load_i       (en_start || reload),
    .load_val_i   (load_val),
    .reload_val_i (tout_cur),
    .expire_o     (expire)
  );

  wdt_rst_gen #(
    .PULSE (RST_PULSE_CYCLES)
  ) u_rst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .expire_i     (expire),
    .rst_out_en_i (ctrl_rst_out),
    .wdog_rst_o   (wdog_rst_o),
    .cause_o      (cause)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_CTRL: reg_rdata_o = ctrl_to_word(ctrl);
      OFS_STAT: reg_rdata_o = {15'b0, cause};
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keyseq_chk.sv
module wdt_keyseq_chk
  import wdt_pkg::*;
#(
  parameter int unsigned RST_PULSE_CYCLES = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [2:0]  reg_addr_i,
  input logic [15:0] reg_wdata_i,
  input logic [15:0] reg_rdata_o,
  input logic        wdog_rst_o,
  input logic        ctrl_en,
  input logic        ctrl_rst_out,
  input logic [7:0]  tout_cur,
  input logic        cause,
  input logic        reload
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= 0;
    else if (wdog_rst_o) run_q <= run_q + 1;
    else                 run_q <= 0;
  end

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_en |=> ctrl_en); // R4
  AST_TOUT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_en |=> $stable(tout_cur)); // R5
  AST_RELOAD_ON_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |-> (reg_we_i && reg_addr_i == OFS_SVC && reg_wdata_i == KEY_FIRE)); // R7
  AST_RST_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdog_rst_o) |-> $past(ctrl_rst_out)); // R10
  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause |=> cause); // R11
  AST_RST_FLAGS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |-> cause); // R11
  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |-> (run_q < RST_PULSE_CYCLES)); // R9
  AST_SVC_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFS_SVC) |-> (reg_rdata_o == 16'h0000)); // R2
endmodule

bind wdt_keyseq wdt_keyseq_chk #(
  .RST_PULSE_CYCLES (RST_PULSE_CYCLES)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .wdog_rst_o   (wdog_rst_o),
  .ctrl_en      (ctrl_en),
  .ctrl_rst_out (ctrl_rst_out),
  .tout_cur     (tout_cur),
  .cause        (cause),
  .reload       (reload)
);

// File: tb/wdt_keyseq_tb_top.sv
`timescale 1ns/1ps
module wdt_keyseq_tb_top;
  localparam int T = 8;
  localparam int P = 4;
  localparam logic [2:0] A_CTRL = 3'd0, A_SVC = 3'd2, A_STAT = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wdog_rst;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, last_wr_cyc = 0;
  int n_rise = 0, rise_cyc = 0, cur_w = 0, last_w = 0;
  logic rst_prev = 1'b0;

  always #5 clk = ~clk;

  wdt_keyseq #(.TICKS_PER_HALF_SECOND(T), .RST_PULSE_CYCLES(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wdog_rst_o(wdog_rst)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wdog_rst) begin
      if (!rst_prev) begin n_rise++; rise_cyc = cyc; cur_w = 0; end
      cur_w++;
    end else if (rst_prev) begin
      last_w = cur_w;
    end
    rst_prev = wdog_rst;
  end

  function automatic int period(input int field);
    return (field + 1) * T;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); last_wr_cyc = cyc; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); addr = a; #1 v = int'(rdata);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_rise(input int base);
    int k = 0;
    while (n_rise <= base && k < 4000) begin @(negedge clk); k++; end
  endtask

  task automatic run();
    int v, t0, t1, base, r1, field, mode, cw;
    void'($urandom(32'd20240611));

    do_reset();
    rd(A_CTRL, v); chk("R1", "ctrl after reset", v, 0);
    rd(A_STAT, v); chk("R1", "status after reset", v, 0);
    chk("R1", "rst out after reset", int'(wdog_rst), 0);

    wr(A_CTRL, 16'h0100);
    wr(A_CTRL, 16'h03FB);
    rd(A_CTRL, v); chk("R2", "ctrl readback, R5 last value", v, 16'h038B);
    rd(A_SVC, v);  chk("R2", "service reads zero", v, 0);
    rd(3'd6, v);   chk("R2", "unused offset", v, 0);

    // random timeouts and mode bits
    for (int i = 0; i < 6; i++) begin
      do_reset();
      field = int'($urandom % 6);
      mode  = ($urandom % 2 == 0 ? 0 : 16'h0080) | int'($urandom % 4);
      cw    = (field << 8) | 16'h000C | mode;
      base  = n_rise;
      wr(A_CTRL, 16'(cw)); t0 = last_wr_cyc;
      rd(A_CTRL, v); chk("R3", "enable readback", v, cw);
      wait_rise(base);
      chk("R6", "expiry delay", rise_cyc - t0, period(field));
      r1 = rise_cyc;
      repeat (P + 2) @(negedge clk);
      chk("R9", "pulse width", last_w, P);
      rd(A_STAT, v); chk("R11", "cause set", v, 1);
      wait_rise(base + 1);
      chk("R12", "repeat expiry", rise_cyc - r1, period(field));
    end

    // valid key pair reloads
    do_reset(); base = n_rise;
    wr(A_CTRL, 16'h020C);
    repeat (10) @(negedge clk);
    wr(A_SVC, 16'h5555); wr(A_SVC, 16'hAAAA); t1 = last_wr_cyc;
    wait_rise(base);
    chk("R7", "reload by key pair", rise_cyc - t1, period(2));

    // broken pair: no reload
    do_reset(); base = n_rise;
    wr(A_CTRL, 16'h020C); t0 = last_wr_cyc;
    wr(A_SVC, 16'h5555); wr(A_SVC, 16'h1234); wr(A_SVC, 16'hAAAA);
    wait_rise(base);
    chk("R8", "interrupted pair ignored", rise_cyc - t0, period(2));

    // lone second key: no reload
    do_reset(); base = n_rise;
    wr(A_CTRL, 16'h020C); t0 = last_wr_cyc;
    repeat (4) @(negedge clk);
    wr(A_SVC, 16'hAAAA);
    wait_rise(base);
    chk("R7", "lone 0xAAAA ignored", rise_cyc - t0, period(2));

    // repeated first key stays armed
    do_reset(); base = n_rise;
    wr(A_CTRL, 16'h020C);
    repeat (5) @(negedge clk);
    wr(A_SVC, 16'h5555); wr(A_SVC, 16'h5555); wr(A_SVC, 16'hAAAA); t1 = last_wr_cyc;
    wait_rise(base);
    chk("R8", "re-armed pair reloads", rise_cyc - t1, period(2));

    // enable and timeout lock
    do_reset(); base = n_rise;
    wr(A_CTRL, 16'h010C); t0 = last_wr_cyc;
    wr(A_CTRL, 16'h0508);
    rd(A_CTRL, v); chk("R4", "enable kept, R5 timeout kept", v, 16'h010C);
    wait_rise(base);
    chk("R4", "countdown not stopped", rise_cyc - t0, period(1));

    // output mode clear
    do_reset(); base = n_rise;
    wr(A_CTRL, 16'h0004);
    repeat (3 * T) @(negedge clk);
    chk("R10", "no reset pulse", n_rise - base, 0);
    rd(A_STAT, v); chk("R11", "cause without pulse", v, 1);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, v); chk("R11", "cause survives write", v, 1);
    do_reset();
    rd(A_STAT, v); chk("R11", "cause cleared by reset", v, 0);
  endtask

  initial begin
    run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule